// File: doc/BRIEF.md
# Run-time-addressed two-wire slave command front end

This block sits behind the SCL and SDA pins of a memory slave on a two-wire, I2C-compatible bus. It does not take its bus address from strap pins. It holds a volatile 8-bit identity register that starts at 00h and is handed out at run time. Every transaction opens with a control byte. Its high nibble is a fixed pattern, followed by an output-enable flag and a three-bit command. For most commands a second byte then carries the identity that the master wants to reach. The block decides, one byte at a time, whether to pull SDA low in the acknowledge slot.

The block keeps track of whether an identity has been assigned. It also keeps a one-shot protection flag. An arbitration datapath outside this block serialises the 48-bit serial number and reports whether this device kept the bus. The write engine is also outside the block and reports when it is busy programming. A one-cycle pulse tells that engine to start a write or protect cycle. An active-low select output can enable nearby circuitry while the device is addressed.

Top module: `swa_front`

## Requirements
- R1: The control byte is the first byte after a Start, sent MSB first. Bits 7:4 must be 0110, bit 3 is the output-enable flag and bits 2:0 are the command. With any other pattern in bits 7:4 the control byte is not acknowledged, and nothing further is acknowledged until the next Start.
- R2: The legal commands are 000 protect, 001 read, 010 write, 100 assign and 110 clear. A control byte carrying 011, 101 or 111 is not acknowledged.
- R3: For write and protect, the control byte is acknowledged. If the second byte equals the identity register, it and every later byte are acknowledged, and the Stop produces a single-cycle pulse on `prog_start_o`.
- R4: For read, the control byte is acknowledged and a matching identity byte is acknowledged. No later byte is acknowledged, and no programming pulse follows.
- R5: For read, write or protect, an identity byte that differs from the register is not acknowledged. Nothing after it is acknowledged and no programming pulse is produced. While unassigned, the register holds 00h.
- R6: While unassigned, an assign command acknowledges the control byte and the identity byte but none of the serial bytes that follow. At Stop, if `arb_won_i` is high, the register takes the identity byte and the state becomes assigned. Otherwise the register and the state are left unchanged.
- R7: While assigned, an assign control byte is not acknowledged.
- R8: A clear command acknowledges the control byte and one don't-care byte in either state. A Stop placed right after that second acknowledge resets the register to 00h and returns the state to unassigned. A Stop placed anywhere else leaves both unchanged.
- R9: While `busy_i` is high, no acknowledge is given.
- R10: Once a protect command has ended with its programming pulse, a protect control byte is never acknowledged again until reset.
- R11: `sel_n_o` goes low together with the acknowledge of a matching identity byte (read, write, protect) or of an assign identity byte, provided the latched output-enable flag is 1. It stays low until the next Stop or Start and is high at all other times.
- R12: After reset the register is 00h, the state is unassigned, the protection flag is clear, SDA is released and `sel_n_o` is high. Start and Stop are detected as SDA edges while the synchronised SCL is high. A repeated Start restarts decoding at the control byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset (power-up) |
| scl_i | input | 1 | Raw serial clock line |
| sda_i | input | 1 | Raw serial data line (wired level) |
| busy_i | input | 1 | Internal programming cycle in progress |
| arb_won_i | input | 1 | Arbitration datapath kept the bus for all serial bits |
| sda_pull_o | output | 1 | 1 pulls SDA low (open-drain acknowledge) |
| sel_n_o | output | 1 | Active-low open-drain select output |
| id_o | output | 8 | Current identity register |
| assigned_o | output | 1 | 1 when an identity has been assigned |
| prog_start_o | output | 1 | One-cycle pulse at Stop of an accepted write or protect |

## Verification
On a single Stop cycle the identity register (or the protection flag) is committed and the command sequencer returns to idle. The decode of the very next control byte must already see the new state. The bench provokes this by placing a Start shortly after each assign, clear and protect Stop and by sending the same or a conflicting command straight away. It judges the outcome from the acknowledge seen on the wired SDA line and from a per-cycle comparison of `id_o` and `assigned_o` against its own behavioural model. An aborted clear, where a Stop follows a third byte, is run the same way, so that an off-by-one in the Stop position shows up as a wrong identity.

// File: rtl/swa_pkg.sv
package swa_pkg;

    localparam int          BYTE_W    = 8;
    localparam logic [3:0]  CTRL_CODE = 4'b0110;

    typedef enum logic [2:0] {
        CMD_PROTECT = 3'b000,
        CMD_READ    = 3'b001,
        CMD_WRITE   = 3'b010,
        CMD_ASSIGN  = 3'b100,
        CMD_CLEAR   = 3'b110
    } cmd_e;

    typedef struct packed {
        logic code_ok;
        logic legal;
        logic oe;
        cmd_e cmd;
    } ctrl_t;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_CTRL,
        SQ_ID,
        SQ_BODY,
        SQ_SERIAL,
        SQ_CLRW,
        SQ_SKIP
    } seq_e;

    function automatic ctrl_t decode_ctrl(input logic [BYTE_W-1:0] b);
        ctrl_t r;
        r.code_ok = (b[7:4] == CTRL_CODE);
        r.oe      = b[3];
        r.cmd     = cmd_e'(b[2:0]);
        case (b[2:0])
            3'b000, 3'b001, 3'b010, 3'b100, 3'b110: r.legal = 1'b1;
            default:                                 r.legal = 1'b0;
        endcase
        return r;
    endfunction

    function automatic logic cmd_programs(input cmd_e c);
        return (c == CMD_WRITE) || (c == CMD_PROTECT);
    endfunction

    function automatic logic cmd_uses_id(input cmd_e c);
        return (c == CMD_WRITE) || (c == CMD_PROTECT) || (c == CMD_READ);
    endfunction

endpackage

// File: rtl/swa_line_sync.sv
module swa_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_p,
    output logic stop_p
);
    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0] scl_sh;
    logic [STAGES-1:0] sda_sh;
    logic              scl_d;
    logic              sda_d;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) begin
                    scl_sh <= '1;
                    sda_sh <= '1;
                end else begin
                    scl_sh <= scl_i;
                    sda_sh <= sda_i;
                end
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst) begin
                    scl_sh <= '1;
                    sda_sh <= '1;
                end else begin
                    scl_sh <= {scl_sh[STAGES-2:0], scl_i};
                    sda_sh <= {sda_sh[STAGES-2:0], sda_i};
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_d <= scl_sh[LAST];
            sda_d <= sda_sh[LAST];
        end
    end

    assign sda_lvl  = sda_sh[LAST];
    assign scl_rise = scl_sh[LAST] & ~scl_d;
    assign scl_fall = ~scl_sh[LAST] & scl_d;
    assign start_p  = scl_sh[LAST] & scl_d & sda_d & ~sda_sh[LAST];
    assign stop_p   = scl_sh[LAST] & scl_d & ~sda_d & sda_sh[LAST];

endmodule

// File: rtl/swa_bit_engine.sv
module swa_bit_engine #(
    parameter int DATA_BITS = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 sda_lvl,
    input  logic                 scl_rise,
    input  logic                 scl_fall,
    input  logic                 start_p,
    input  logic                 stop_p,
    input  logic                 ack_req,
    output logic                 byte_done,
    output logic [DATA_BITS-1:0] rx_byte,
    output logic                 bits_pending,
    output logic                 sda_pull
);
    localparam int                 CNT_W = $clog2(DATA_BITS + 1);
    localparam logic [CNT_W-1:0]   FULL  = CNT_W'(DATA_BITS);
    localparam logic [CNT_W-1:0]   ONE   = CNT_W'(1);

    logic [CNT_W-1:0]     bitcnt;
    logic                 ack_ph;
    logic [DATA_BITS-1:0] shreg;

    assign byte_done    = scl_fall && (bitcnt == FULL) && !ack_ph;
    assign rx_byte      = shreg;
    assign bits_pending = (bitcnt > ONE) || ack_ph;

    always_ff @(posedge clk) begin
        if (rst || start_p || stop_p) begin
            bitcnt   <= '0;
            ack_ph   <= 1'b0;
            sda_pull <= 1'b0;
            if (rst) shreg <= '0;
        end else if (scl_rise && !ack_ph && (bitcnt < FULL)) begin
            shreg  <= {shreg[DATA_BITS-2:0], sda_lvl};
            bitcnt <= bitcnt + ONE;
        end else if (byte_done) begin
            ack_ph   <= 1'b1;
            sda_pull <= ack_req;
        end else if (scl_fall && ack_ph) begin
            ack_ph   <= 1'b0;
            bitcnt   <= '0;
            sda_pull <= 1'b0;
        end
    end

endmodule

// File: rtl/swa_cmd_seq.sv
module swa_cmd_seq
    import swa_pkg::*;
#(
    parameter int ID_W = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start_p,
    input  logic            stop_p,
    input  logic            byte_done,
    input  logic [ID_W-1:0] rx_byte,
    input  logic            bits_pending,
    input  logic            busy_i,
    input  logic            arb_won_i,
    output logic            ack_req,
    output logic            sel_n_o,
    output logic [ID_W-1:0] id_o,
    output logic            assigned_o,
    output logic            prog_start_o
);
    seq_e            state, nxt;
    cmd_e            cmd_q;
    logic            oe_q;
    logic [ID_W-1:0] id_q;
    logic [ID_W-1:0] new_id_q;
    logic            asg_q;
    logic            fuse_q;
    logic            sel_q;
    logic            prog_q;
    ctrl_t           ctl;

    always_comb begin
        ctl     = decode_ctrl(rx_byte);
        ack_req = 1'b0;
        nxt     = state;
        if (byte_done) begin
            case (state)
                SQ_CTRL: begin
                    ack_req = ctl.code_ok && ctl.legal && !busy_i
                              && !((ctl.cmd == CMD_ASSIGN) && asg_q)
                              && !((ctl.cmd == CMD_PROTECT) && fuse_q);
                    nxt = ack_req ? SQ_ID : SQ_SKIP;
                end
                SQ_ID: begin
                    if (cmd_q == CMD_ASSIGN) begin
                        ack_req = !busy_i;
                        nxt     = ack_req ? SQ_SERIAL : SQ_SKIP;
                    end else if (cmd_q == CMD_CLEAR) begin
                        ack_req = !busy_i;
                        nxt     = ack_req ? SQ_CLRW : SQ_SKIP;
                    end else begin
                        ack_req = (rx_byte == id_q) && !busy_i;
                        nxt     = ack_req ? SQ_BODY : SQ_SKIP;
                    end
                end
                SQ_BODY:  ack_req = cmd_programs(cmd_q) && !busy_i;
                SQ_CLRW:  nxt = SQ_SKIP;
                default:  ack_req = 1'b0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= SQ_IDLE;
            cmd_q    <= CMD_READ;
            oe_q     <= 1'b0;
            id_q     <= '0;
            new_id_q <= '0;
            asg_q    <= 1'b0;
            fuse_q   <= 1'b0;
            sel_q    <= 1'b0;
            prog_q   <= 1'b0;
        end else begin
            prog_q <= 1'b0;
            if (start_p) begin
                state <= SQ_CTRL;
                sel_q <= 1'b0;
            end else if (stop_p) begin
                state <= SQ_IDLE;
                sel_q <= 1'b0;
                if ((state == SQ_SERIAL) && arb_won_i) begin
                    id_q  <= new_id_q;
                    asg_q <= 1'b1;
                end
                if ((state == SQ_CLRW) && !bits_pending) begin
                    id_q  <= '0;
                    asg_q <= 1'b0;
                end
                if ((state == SQ_BODY) && cmd_programs(cmd_q)) begin
                    prog_q <= 1'b1;
                    if (cmd_q == CMD_PROTECT) fuse_q <= 1'b1;
                end
            end else begin
                state <= nxt;
                if (byte_done && (state == SQ_CTRL)) begin
                    cmd_q <= ctl.cmd;
                    oe_q  <= ctl.oe;
                end
                if (byte_done && (state == SQ_ID) && ack_req) begin
                    if (cmd_q == CMD_ASSIGN) new_id_q <= rx_byte;
                    if (cmd_q != CMD_CLEAR) sel_q <= 1'b1;
                end
            end
        end
    end

    assign sel_n_o      = ~(sel_q & oe_q);
    assign id_o         = id_q;
    assign assigned_o   = asg_q;
    assign prog_start_o = prog_q;

    logic unused_ok;
    assign unused_ok = cmd_uses_id(cmd_q);

endmodule

// File: rtl/swa_front.sv
module swa_front
    import swa_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int ID_W        = BYTE_W
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            scl_i,
    input  logic            sda_i,
    input  logic            busy_i,
    input  logic            arb_won_i,
    output logic            sda_pull_o,
    output logic            sel_n_o,
    output logic [ID_W-1:0] id_o,
    output logic            assigned_o,
    output logic            prog_start_o
);
    logic            sda_lvl;
    logic            scl_rise;
    logic            scl_fall;
    logic            start_p;
    logic            stop_p;
    logic            ack_req;
    logic            byte_done;
    logic [ID_W-1:0] rx_byte;
    logic            bits_pending;

    swa_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .scl_i    (scl_i),
        .sda_i    (sda_i),
        .sda_lvl  (sda_lvl),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_p  (start_p),
        .stop_p   (stop_p)
    );

    swa_bit_engine #(.DATA_BITS(ID_W)) u_bits (
        .clk          (clk),
        .rst          (rst),
        .sda_lvl      (sda_lvl),
        .scl_rise     (scl_rise),
        .scl_fall     (scl_fall),
        .start_p      (start_p),
        .stop_p       (stop_p),
        .ack_req      (ack_req),
        .byte_done    (byte_done),
        .rx_byte      (rx_byte),
        .bits_pending (bits_pending),
        .sda_pull     (sda_pull_o)
    );

    swa_cmd_seq #(.ID_W(ID_W)) u_seq (
        .clk          (clk),
        .rst          (rst),
        .start_p      (start_p),
        .stop_p       (stop_p),
        .byte_done    (byte_done),
        .rx_byte      (rx_byte),
        .bits_pending (bits_pending),
        .busy_i       (busy_i),
        .arb_won_i    (arb_won_i),
        .ack_req      (ack_req),
        .sel_n_o      (sel_n_o),
        .id_o         (id_o),
        .assigned_o   (assigned_o),
        .prog_start_o (prog_start_o)
    );

endmodule

// File: rtl/swa_front_chk.sv
module swa_front_chk #(
    parameter int ID_W = 8
) (
    input logic            clk,
    input logic            rst,
    input logic            scl_fall,
    input logic            stop_p,
    input logic            busy_i,
    input logic            arb_won_i,
    input logic            sda_pull_o,
    input logic            sel_n_o,
    input logic [ID_W-1:0] id_o,
    input logic            assigned_o,
    input logic            prog_start_o
);
    AST_PULL_ONLY_AFTER_FALL: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_pull_o) |-> $past(scl_fall)); // R12

    AST_NO_ACK_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_pull_o) |-> !$past(busy_i)); // R9

    AST_SELECT_WITH_ACK: assert property (@(posedge clk) disable iff (rst)
        $fell(sel_n_o) |-> $rose(sda_pull_o)); // R11

    AST_PROG_AFTER_STOP: assert property (@(posedge clk) disable iff (rst)
        prog_start_o |-> $past(stop_p)); // R3

    AST_PROG_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        prog_start_o |=> !prog_start_o); // R3

    AST_ID_MOVES_ON_STOP: assert property (@(posedge clk) disable iff (rst)
        !$stable(id_o) |-> $past(stop_p)); // R8

    AST_ASSIGN_NEEDS_WIN: assert property (@(posedge clk) disable iff (rst)
        $rose(assigned_o) |-> ($past(stop_p) && $past(arb_won_i))); // R6

endmodule

bind swa_front swa_front_chk #(.ID_W(ID_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .scl_fall     (scl_fall),
    .stop_p       (stop_p),
    .busy_i       (busy_i),
    .arb_won_i    (arb_won_i),
    .sda_pull_o   (sda_pull_o),
    .sel_n_o      (sel_n_o),
    .id_o         (id_o),
    .assigned_o   (assigned_o),
    .prog_start_o (prog_start_o)
);

// File: tb/swa_front_tb.sv
`timescale 1ns/1ps
module swa_front_tb;
    localparam int H = 8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       busy = 1'b0;
    logic       arb_won = 1'b0;
    logic       sda_pull;
    logic       sel_n;
    logic [7:0] id;
    logic       assigned;
    logic       prog;
    logic       sda_line;

    int checks = 0;
    int errors = 0;
    int prog_cnt = 0;
    logic       model_live = 1'b0;
    logic [7:0] exp_id = 8'h00;
    logic       exp_asg = 1'b0;
    logic       exp_fuse = 1'b0;

    always #10 clk = ~clk;

    assign sda_line = sda_m & ~sda_pull;

    swa_front u_dut (
        .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_line),
        .busy_i(busy), .arb_won_i(arb_won),
        .sda_pull_o(sda_pull), .sel_n_o(sel_n), .id_o(id),
        .assigned_o(assigned), .prog_start_o(prog)
    );

    always @(negedge clk) begin
        if (prog) prog_cnt++;
        if (model_live) begin
            checks++;
            if (id !== exp_id || assigned !== exp_asg) begin
                errors++;
                $display("FAIL R6 R8 model: id=%h asg=%b expected id=%h asg=%b",
                         id, assigned, exp_id, exp_asg);
            end
        end
    end

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wait_h(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wait_h(H);
        scl_m = 1'b1; wait_h(H);
        sda_m = 1'b0; wait_h(H);
        scl_m = 1'b0;
    endtask

    task automatic bus_stop();
        model_live = 1'b0;
        sda_m = 1'b0; wait_h(H);
        scl_m = 1'b1; wait_h(H);
        sda_m = 1'b1; wait_h(2*H);
        chk(sel_n === 1'b1, "R11 sel released at stop", sel_n, 1);
    endtask

    task automatic resume_model();
        model_live = 1'b1;
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked, output logic seln);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; wait_h(H);
            scl_m = 1'b1; wait_h(H);
            scl_m = 1'b0;
        end
        sda_m = 1'b1; wait_h(H);
        scl_m = 1'b1; wait_h(H/2);
        acked = (sda_line == 1'b0);
        seln  = sel_n;
        wait_h(H/2);
        scl_m = 1'b0;
    endtask

    task automatic expect_byte(input logic [7:0] b, input logic exp_ack, input string tag);
        logic a, s;
        send_byte(b, a, s);
        chk(a === exp_ack, tag, a, exp_ack);
    endtask

    initial begin
        logic a, s;
        int pc;
        wait_h(10);
        rst = 1'b0;
        wait_h(2);
        chk(sda_pull === 1'b0, "R12 reset sda released", sda_pull, 0);
        chk(sel_n === 1'b1, "R12 reset sel high", sel_n, 1);
        chk(id === 8'h00, "R12 reset id", id, 0);
        chk(assigned === 1'b0, "R12 reset unassigned", assigned, 0);
        resume_model();

        // R1 wrong control code
        bus_start();
        expect_byte(8'hA2, 1'b0, "R1 bad code not acked");
        expect_byte(8'h00, 1'b0, "R1 later byte ignored");
        bus_stop(); resume_model();

        // R3 write to 00h while unassigned, OE=1
        pc = prog_cnt;
        bus_start();
        expect_byte(8'h6A, 1'b1, "R3 write ctrl acked");
        send_byte(8'h00, a, s);
        chk(a === 1'b1, "R3 id match acked", a, 1);
        chk(s === 1'b0, "R11 sel low after id ack", s, 0);
        expect_byte(8'h10, 1'b1, "R3 address acked");
        expect_byte(8'h5A, 1'b1, "R3 data acked");
        bus_stop(); resume_model();
        chk(prog_cnt == pc + 1, "R3 prog pulse", prog_cnt - pc, 1);

        // R5 read with mismatching id
        pc = prog_cnt;
        bus_start();
        expect_byte(8'h61, 1'b1, "R5 read ctrl acked");
        expect_byte(8'h55, 1'b0, "R5 mismatch id not acked");
        expect_byte(8'h00, 1'b0, "R5 later byte not acked");
        bus_stop(); resume_model();
        chk(prog_cnt == pc, "R5 no prog", prog_cnt - pc, 0);

        // R4 read with match
        bus_start();
        expect_byte(8'h69, 1'b1, "R4 read ctrl acked");
        send_byte(8'h00, a, s);
        chk(a === 1'b1, "R4 read id acked", a, 1);
        chk(s === 1'b0, "R11 read sel low", s, 0);
        expect_byte(8'hFF, 1'b0, "R4 no ack after id");
        bus_stop(); resume_model();
        chk(prog_cnt == pc, "R4 no prog", prog_cnt - pc, 0);

        // R2 illegal commands
        bus_start();
        expect_byte(8'h63, 1'b0, "R2 cmd 011 not acked");
        bus_start();
        expect_byte(8'h65, 1'b0, "R2 cmd 101 not acked");
        bus_start();
        expect_byte(8'h67, 1'b0, "R2 cmd 111 not acked");
        bus_stop(); resume_model();

        // R6 assign 3Ch, win, OE=0
        arb_won = 1'b1;
        bus_start();
        expect_byte(8'h64, 1'b1, "R6 assign ctrl acked");
        send_byte(8'h3C, a, s);
        chk(a === 1'b1, "R6 assign id acked", a, 1);
        chk(s === 1'b1, "R11 sel stays high with OE 0", s, 1);
        for (int k = 0; k < 6; k++) expect_byte(8'hA5, 1'b0, "R6 serial byte not acked");
        bus_stop();
        exp_id = 8'h3C; exp_asg = 1'b1; resume_model();
        arb_won = 1'b0;

        // R7 assign while assigned
        bus_start();
        expect_byte(8'h64, 1'b0, "R7 assign refused when assigned");
        bus_stop(); resume_model();

        // R5 old id 00h now mismatches
        bus_start();
        expect_byte(8'h62, 1'b1, "R5 write ctrl acked");
        expect_byte(8'h00, 1'b0, "R5 id 00 refused when assigned");
        bus_stop(); resume_model();

        // R3 write to assigned id
        pc = prog_cnt;
        bus_start();
        expect_byte(8'h62, 1'b1, "R3 write ctrl acked");
        expect_byte(8'h3C, 1'b1, "R3 assigned id acked");
        expect_byte(8'h01, 1'b1, "R3 data acked");
        bus_stop(); resume_model();
        chk(prog_cnt == pc + 1, "R3 prog pulse assigned", prog_cnt - pc, 1);

        // R9 busy
        busy = 1'b1;
        bus_start();
        expect_byte(8'h62, 1'b0, "R9 no ack while busy");
        bus_stop(); resume_model();
        busy = 1'b0;

        // R8 clear aborted by extra byte
        bus_start();
        expect_byte(8'h66, 1'b1, "R8 clear ctrl acked");
        expect_byte(8'h00, 1'b1, "R8 dont-care acked");
        expect_byte(8'h00, 1'b0, "R8 third byte not acked");
        bus_stop(); resume_model();
        chk(id === 8'h3C, "R8 aborted clear keeps id", id, 8'h3C);

        // R8 clear aborted early
        bus_start();
        expect_byte(8'h66, 1'b1, "R8 clear ctrl acked");
        bus_stop(); resume_model();
        chk(assigned === 1'b1, "R8 early stop keeps state", assigned, 1);

        // R8 proper clear
        bus_start();
        expect_byte(8'h66, 1'b1, "R8 clear ctrl acked");
        expect_byte(8'hFF, 1'b1, "R8 dont-care acked");
        bus_stop();
        exp_id = 8'h00; exp_asg = 1'b0; resume_model();
        chk(id === 8'h00, "R8 clear resets id", id, 0);

        // R6 assign lost arbitration
        bus_start();
        expect_byte(8'h64, 1'b1, "R6 assign ctrl acked again");
        expect_byte(8'h77, 1'b1, "R6 assign id acked");
        for (int k = 0; k < 6; k++) expect_byte(8'h00, 1'b0, "R6 serial byte not acked");
        bus_stop(); resume_model();
        chk(assigned === 1'b0, "R6 lost keeps unassigned", assigned, 0);

        // R10 protect once
        pc = prog_cnt;
        bus_start();
        expect_byte(8'h60, 1'b1, "R10 protect ctrl acked");
        expect_byte(8'h00, 1'b1, "R10 protect id acked");
        bus_stop(); resume_model();
        exp_fuse = 1'b1;
        chk(prog_cnt == pc + 1, "R10 protect prog pulse", prog_cnt - pc, 1);
        bus_start();
        expect_byte(8'h60, 1'b0, "R10 protect refused after fuse");
        bus_stop(); resume_model();

        // R12 repeated start restarts decode
        bus_start();
        expect_byte(8'h62, 1'b1, "R12 first ctrl acked");
        bus_start();
        expect_byte(8'h62, 1'b1, "R12 ctrl after repeated start acked");
        expect_byte(8'h00, 1'b1, "R12 id acked after restart");
        bus_stop(); resume_model();

        model_live = 1'b0;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule